// File: doc/BRIEF.md
# Subroutine Stack Call/Return Engine

This block runs the stack side of an 8-bit microcontroller core. It owns the 8-bit stack pointer and the 16-bit program counter. It executes byte push, byte pop, short call, long call, return and return-from-interrupt as short fixed sequences against an internal byte RAM. The RAM is reached through one single-port interface that makes at most one access per cycle. The RAM read port is asynchronous: read data for the address driven in a cycle is valid in that same cycle.

The decoder hands over a command with its operands already split out: a direct RAM address for push and pop, a target address for calls, and the instruction length by which push and pop advance the program counter. The stack grows upward. A write first increments the pointer and then stores at the new location. A read fetches at the current location and then decrements the pointer. Return addresses go onto the stack low byte first. The engine changes no status flag. When a sequence ends it raises a one-cycle done pulse. A return-from-interrupt also raises a separate one-cycle marker for the interrupt logic.

Top module: `stack_seq`

## Requirements
- R1: After reset the stack pointer is 8'h07, the program counter is 16'h0000, and busy, done, the interrupt-return marker and the RAM enable are all low.
- R2: Push is opcode 0. It reads RAM at the direct address. It then increments the stack pointer by one and writes the byte read at the new stack pointer. The program counter advances by the command length (0 to 3).
- R3: Pop is opcode 1. It reads RAM at the current stack pointer and then decrements the stack pointer by one. It writes the byte read to the direct address. The program counter advances by the command length.
- R4: Short call is opcode 2 and long call is opcode 3. The return address is the program counter plus 2 for a short call and plus 3 for a long call. Its low byte is written at SP+1 and its high byte at SP+2, and the stack pointer ends two higher.
- R5: A long call loads all 16 program counter bits from the target operand.
- R6: A short call loads program counter bits 10..0 from target bits 10..0. It keeps bits 15..11 of the already advanced program counter, including any carry into bit 11.
- R7: Return is opcode 4. It loads PC[15:8] from RAM at SP and PC[7:0] from RAM at SP-1, and the stack pointer ends two lower.
- R8: Return-from-interrupt is opcode 5. It behaves exactly like return, and it also raises the interrupt-return marker in the same cycle as done. After a plain return the marker stays low.
- R9: The stack pointer wraps modulo 256. A pop at 8'h00 leaves 8'hFF, and a push at 8'hFF writes address 8'h00.
- R10: Every accepted command makes exactly two RAM accesses. These fall in the first and second cycles after the accepting clock edge. Done is high only in the third cycle, for exactly one cycle.
- R11: A command request is ignored while the engine is busy, and opcodes 6 and 7 are always ignored. An ignored request causes no RAM access and no done pulse, and leaves the stack pointer and program counter unchanged.
- R12: In each cycle the stack pointer moves by at most one step and the program counter takes at most one kind of update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command request, taken only while idle |
| cmd_op_i | input | 3 | Opcode: 0 push, 1 pop, 2 short call, 3 long call, 4 return, 5 return-from-interrupt |
| cmd_dir_i | input | 8 | Direct RAM address (push source, pop destination) |
| cmd_target_i | input | 16 | Call target (short call uses bits 10..0) |
| cmd_len_i | input | 2 | Program counter advance for push and pop |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| irq_ret_o | output | 1 | One-cycle marker with done after return-from-interrupt |
| sp_o | output | 8 | Stack pointer |
| pc_o | output | 16 | Program counter |
| ram_en_o | output | 1 | RAM access this cycle |
| ram_we_o | output | 1 | RAM write (with enable) |
| ram_addr_o | output | 8 | RAM address |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data, same cycle as address |

## Verification
Every command has the same latency. Counting from the clock edge that accepts it, the RAM is enabled in cycles one and two, and done (together with the interrupt-return marker) is due in cycle three. The new stack pointer, program counter and RAM contents are all settled once done has fallen. The bench samples on the falling clock edge: it checks the enable in the two access cycles, checks done in cycle three, checks that done has dropped in cycle four, and then compares the pointer, the counter and a full image of the RAM with its own model. A request held through the busy cycles and an undefined opcode are both checked in the same cycle-accurate way.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  typedef enum logic [2:0] {
    OP_PUSH  = 3'd0,
    OP_POP   = 3'd1,
    OP_SCALL = 3'd2,
    OP_LCALL = 3'd3,
    OP_RET   = 3'd4,
    OP_RETI  = 3'd5
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SRC_RD,
    ST_STK_WR,
    ST_STK_RD,
    ST_DST_WR,
    ST_LO_WR,
    ST_HI_WR,
    ST_HI_RD,
    ST_LO_RD,
    ST_DONE
  } st_e;

  typedef enum logic [1:0] {
    AS_DIR,
    AS_SP,
    AS_SP_NEXT
  } asel_e;

  typedef enum logic [1:0] {
    WS_TMP,
    WS_PC_LO,
    WS_PC_HI
  } wsel_e;

  localparam logic [2:0] OP_LAST = 3'd5;

endpackage

// File: rtl/ss_sp_unit.sv
module ss_sp_unit #(
  parameter int unsigned    AW     = 8,
  parameter logic [AW-1:0]  SP_RST = 8'h07
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] sp_next_o
);

  logic [AW-1:0] sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sp_q <= SP_RST;
    else if (inc_i) sp_q <= sp_q + AW'(1);
    else if (dec_i) sp_q <= sp_q - AW'(1);
  end

  assign sp_o      = sp_q;
  assign sp_next_o = sp_q + AW'(1);

  AST_SP_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inc_i && dec_i)); // R12

  AST_SP_WRAP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && (&sp_q)) |=> (sp_q == '0)); // R9

  AST_SP_WRAP_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && (sp_q == '0)) |=> (&sp_q)); // R9

endmodule

// File: rtl/ss_pc_unit.sv
module ss_pc_unit #(
  parameter int unsigned PCW     = 16,
  parameter int unsigned SHORT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [1:0]       step_i,
  input  logic             jump_i,
  input  logic             short_i,
  input  logic [PCW-1:0]   target_i,
  input  logic             ld_hi_i,
  input  logic             ld_lo_i,
  input  logic [PCW/2-1:0] byte_i,
  output logic [PCW-1:0]   pc_o
);

  localparam int unsigned HALF = PCW / 2;

  logic [PCW-1:0] pc_q;
  logic [PCW-1:0] jump_val;

  generate
    if (SHORT_W < PCW) begin : g_short
      // short form keeps the page bits of the advanced PC
      assign jump_val = short_i ? {pc_q[PCW-1:SHORT_W], target_i[SHORT_W-1:0]}
                                : target_i;

      AST_SHORT_KEEP_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (jump_i && short_i) |=> (pc_q[PCW-1:SHORT_W] == $past(pc_q[PCW-1:SHORT_W]))); // R6
    end else begin : g_full
      assign jump_val = target_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_q <= '0;
    else if (adv_i)   pc_q <= pc_q + PCW'(step_i);
    else if (jump_i)  pc_q <= jump_val;
    else if (ld_hi_i) pc_q[PCW-1:HALF] <= byte_i;
    else if (ld_lo_i) pc_q[HALF-1:0]   <= byte_i;
  end

  assign pc_o = pc_q;

  AST_PC_ONE_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({adv_i, jump_i, ld_hi_i, ld_lo_i})); // R12

  AST_LONG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_i && !short_i) |=> (pc_q == $past(target_i))); // R5

endmodule

// File: rtl/ss_ctrl.sv
module ss_ctrl
  import stack_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  input  logic [2:0]  cmd_op_i,
  input  logic [1:0]  cmd_len_i,
  output logic        accept_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        irq_ret_o,
  output logic        ram_en_o,
  output logic        ram_we_o,
  output asel_e       asel_o,
  output wsel_e       wsel_o,
  output logic        tmp_ld_o,
  output logic        sp_inc_o,
  output logic        sp_dec_o,
  output logic        pc_adv_o,
  output logic [1:0]  pc_step_o,
  output logic        pc_jump_o,
  output logic        pc_short_o,
  output logic        pc_ld_hi_o,
  output logic        pc_ld_lo_o
);

  st_e st_q, st_d;
  op_e op_q;
  op_e op_in;

  assign op_in = op_e'(cmd_op_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      op_q <= OP_PUSH;
    end else begin
      st_q <= st_d;
      if (accept_o) op_q <= op_in;
    end
  end

  always_comb begin
    st_d       = st_q;
    accept_o   = 1'b0;
    done_o     = 1'b0;
    irq_ret_o  = 1'b0;
    ram_en_o   = 1'b0;
    ram_we_o   = 1'b0;
    asel_o     = AS_DIR;
    wsel_o     = WS_TMP;
    tmp_ld_o   = 1'b0;
    sp_inc_o   = 1'b0;
    sp_dec_o   = 1'b0;
    pc_adv_o   = 1'b0;
    pc_step_o  = 2'd0;
    pc_jump_o  = 1'b0;
    pc_short_o = 1'b0;
    pc_ld_hi_o = 1'b0;
    pc_ld_lo_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        accept_o = cmd_valid_i && (cmd_op_i <= OP_LAST);
        if (accept_o) begin
          unique case (op_in)
            OP_PUSH: begin
              st_d = ST_SRC_RD; pc_adv_o = 1'b1; pc_step_o = cmd_len_i;
            end
            OP_POP: begin
              st_d = ST_STK_RD; pc_adv_o = 1'b1; pc_step_o = cmd_len_i;
            end
            OP_SCALL: begin
              st_d = ST_LO_WR; pc_adv_o = 1'b1; pc_step_o = 2'd2;
            end
            OP_LCALL: begin
              st_d = ST_LO_WR; pc_adv_o = 1'b1; pc_step_o = 2'd3;
            end
            default: st_d = ST_HI_RD;
          endcase
        end
      end
      ST_SRC_RD: begin
        ram_en_o = 1'b1; asel_o = AS_DIR; tmp_ld_o = 1'b1;
        st_d = ST_STK_WR;
      end
      ST_STK_WR: begin
        ram_en_o = 1'b1; ram_we_o = 1'b1; asel_o = AS_SP_NEXT; wsel_o = WS_TMP;
        sp_inc_o = 1'b1;
        st_d = ST_DONE;
      end
      ST_STK_RD: begin
        ram_en_o = 1'b1; asel_o = AS_SP; tmp_ld_o = 1'b1; sp_dec_o = 1'b1;
        st_d = ST_DST_WR;
      end
      ST_DST_WR: begin
        ram_en_o = 1'b1; ram_we_o = 1'b1; asel_o = AS_DIR; wsel_o = WS_TMP;
        st_d = ST_DONE;
      end
      ST_LO_WR: begin
        ram_en_o = 1'b1; ram_we_o = 1'b1; asel_o = AS_SP_NEXT; wsel_o = WS_PC_LO;
        sp_inc_o = 1'b1;
        st_d = ST_HI_WR;
      end
      ST_HI_WR: begin
        ram_en_o = 1'b1; ram_we_o = 1'b1; asel_o = AS_SP_NEXT; wsel_o = WS_PC_HI;
        sp_inc_o = 1'b1;
        pc_jump_o = 1'b1; pc_short_o = (op_q == OP_SCALL);
        st_d = ST_DONE;
      end
      ST_HI_RD: begin
        ram_en_o = 1'b1; asel_o = AS_SP; pc_ld_hi_o = 1'b1; sp_dec_o = 1'b1;
        st_d = ST_LO_RD;
      end
      ST_LO_RD: begin
        ram_en_o = 1'b1; asel_o = AS_SP; pc_ld_lo_o = 1'b1; sp_dec_o = 1'b1;
        st_d = ST_DONE;
      end
      ST_DONE: begin
        done_o    = 1'b1;
        irq_ret_o = (op_q == OP_RETI);
        st_d      = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign busy_o = (st_q != ST_IDLE);

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10

  AST_DONE_AFTER_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(ram_en_o)); // R10

  AST_ACCEPT_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> ram_en_o); // R10

  AST_IRQ_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ret_o |-> done_o); // R8

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int unsigned   AW      = 8,
  parameter int unsigned   PCW     = 16,
  parameter int unsigned   SHORT_W = 11,
  parameter logic [AW-1:0] SP_RST  = 8'h07
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_valid_i,
  input  logic [2:0]     cmd_op_i,
  input  logic [AW-1:0]  cmd_dir_i,
  input  logic [PCW-1:0] cmd_target_i,
  input  logic [1:0]     cmd_len_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           irq_ret_o,
  output logic [AW-1:0]  sp_o,
  output logic [PCW-1:0] pc_o,
  output logic           ram_en_o,
  output logic           ram_we_o,
  output logic [AW-1:0]  ram_addr_o,
  output logic [7:0]     ram_wdata_o,
  input  logic [7:0]     ram_rdata_i
);

  localparam int unsigned HALF = PCW / 2;

  logic           accept;
  asel_e          asel;
  wsel_e          wsel;
  logic           tmp_ld, sp_inc, sp_dec;
  logic           pc_adv, pc_jump, pc_short, pc_ld_hi, pc_ld_lo;
  logic [1:0]     pc_step;
  logic [AW-1:0]  sp, sp_next;
  logic [AW-1:0]  dir_q;
  logic [PCW-1:0] tgt_q;
  logic [7:0]     tmp_q;

  ss_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_len_i   (cmd_len_i),
    .accept_o    (accept),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .irq_ret_o   (irq_ret_o),
    .ram_en_o    (ram_en_o),
    .ram_we_o    (ram_we_o),
    .asel_o      (asel),
    .wsel_o      (wsel),
    .tmp_ld_o    (tmp_ld),
    .sp_inc_o    (sp_inc),
    .sp_dec_o    (sp_dec),
    .pc_adv_o    (pc_adv),
    .pc_step_o   (pc_step),
    .pc_jump_o   (pc_jump),
    .pc_short_o  (pc_short),
    .pc_ld_hi_o  (pc_ld_hi),
    .pc_ld_lo_o  (pc_ld_lo)
  );

  ss_sp_unit #(.AW(AW), .SP_RST(SP_RST)) u_sp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (sp_inc),
    .dec_i     (sp_dec),
    .sp_o      (sp),
    .sp_next_o (sp_next)
  );

  ss_pc_unit #(.PCW(PCW), .SHORT_W(SHORT_W)) u_pc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (pc_adv),
    .step_i   (pc_step),
    .jump_i   (pc_jump),
    .short_i  (pc_short),
    .target_i (tgt_q),
    .ld_hi_i  (pc_ld_hi),
    .ld_lo_i  (pc_ld_lo),
    .byte_i   (ram_rdata_i),
    .pc_o     (pc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      tgt_q <= '0;
      tmp_q <= '0;
    end else begin
      if (accept) begin
        dir_q <= cmd_dir_i;
        tgt_q <= cmd_target_i;
      end
      if (tmp_ld) tmp_q <= ram_rdata_i;
    end
  end

  always_comb begin
    unique case (asel)
      AS_SP:      ram_addr_o = sp;
      AS_SP_NEXT: ram_addr_o = sp_next;
      default:    ram_addr_o = dir_q;
    endcase
    unique case (wsel)
      WS_PC_LO: ram_wdata_o = pc_o[HALF-1:0];
      WS_PC_HI: ram_wdata_o = pc_o[PCW-1:HALF];
      default:  ram_wdata_o = tmp_q;
    endcase
  end

  assign sp_o = sp;

  AST_PUSH_AT_NEW_SP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && sp_inc) |=> (sp == $past(ram_addr_o))); // R2

  AST_POP_AT_OLD_SP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_dec |-> (ram_en_o && !ram_we_o && (ram_addr_o == sp))); // R3

  AST_IDLE_NO_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o) |-> !ram_en_o); // R11

endmodule

// File: tb/tb_stack_seq.sv
module tb_stack_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [7:0]  cmd_dir = 8'd0;
  logic [15:0] cmd_target = 16'd0;
  logic [1:0]  cmd_len = 2'd0;
  logic        busy, done, irq_ret, ram_en, ram_we;
  logic [7:0]  sp, ram_addr, ram_wdata, ram_rdata;
  logic [15:0] pc;

  logic [7:0]  mem [256];
  logic [7:0]  exp_mem [256];
  logic [7:0]  exp_sp;
  logic [15:0] exp_pc;
  int          errors = 0;
  int          checks = 0;

  always #2 clk = ~clk;

  stack_seq dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cmd_valid_i  (cmd_valid),
    .cmd_op_i     (cmd_op),
    .cmd_dir_i    (cmd_dir),
    .cmd_target_i (cmd_target),
    .cmd_len_i    (cmd_len),
    .busy_o       (busy),
    .done_o       (done),
    .irq_ret_o    (irq_ret),
    .sp_o         (sp),
    .pc_o         (pc),
    .ram_en_o     (ram_en),
    .ram_we_o     (ram_we),
    .ram_addr_o   (ram_addr),
    .ram_wdata_o  (ram_wdata),
    .ram_rdata_i  (ram_rdata)
  );

  function automatic logic [7:0] init_byte(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  assign ram_rdata = mem[ram_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_byte(i);
    end else if (ram_en && ram_we) begin
      mem[ram_addr] <= ram_wdata;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_mem(input string tag);
    int bad = -1;
    checks++;
    for (int i = 0; i < 256; i++) if (bad < 0 && mem[i] !== exp_mem[i]) bad = i;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s mem[%0h] act=%0h exp=%0h", tag, bad, mem[bad], exp_mem[bad]);
    end
  endtask

  // reference model of one accepted command
  task automatic model(input logic [2:0] op, input logic [7:0] dir,
                       input logic [15:0] tgt, input logic [1:0] len);
    logic [7:0]  v;
    logic [15:0] ra;
    case (op)
      3'd0: begin
        v = exp_mem[dir]; exp_sp = exp_sp + 8'd1; exp_mem[exp_sp] = v;
        exp_pc = exp_pc + 16'(len);
      end
      3'd1: begin
        v = exp_mem[exp_sp]; exp_sp = exp_sp - 8'd1; exp_mem[dir] = v;
        exp_pc = exp_pc + 16'(len);
      end
      3'd2, 3'd3: begin
        ra = exp_pc + ((op == 3'd2) ? 16'd2 : 16'd3);
        exp_mem[8'(exp_sp + 8'd1)] = ra[7:0];
        exp_mem[8'(exp_sp + 8'd2)] = ra[15:8];
        exp_sp = exp_sp + 8'd2;
        exp_pc = (op == 3'd3) ? tgt : {ra[15:11], tgt[10:0]};
      end
      default: begin
        exp_pc = {exp_mem[exp_sp], exp_mem[8'(exp_sp - 8'd1)]};
        exp_sp = exp_sp - 8'd2;
      end
    endcase
  endtask

  // hold_busy: keep requesting a pop through the busy cycles (R11)
  task automatic run_cmd(input string tag, input logic [2:0] op, input logic [7:0] dir,
                         input logic [15:0] tgt, input logic [1:0] len, input bit hold_busy);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_dir = dir; cmd_target = tgt; cmd_len = len;
    model(op, dir, tgt, len);
    @(posedge clk);
    @(negedge clk);
    if (hold_busy) begin
      cmd_op = 3'd1; cmd_dir = 8'hEE;
    end else cmd_valid = 1'b0;
    chk("R10", "access1 en", 32'(ram_en), 1);
    @(negedge clk);
    chk("R10", "access2 en", 32'(ram_en), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10", "done", 32'(done), 1);
    chk(tag, "irq_ret", 32'(irq_ret), (op == 3'd5) ? 1 : 0);
    @(negedge clk);
    chk("R10", "done drop", 32'(done), 0);
    chk(hold_busy ? "R11" : "R12", "idle after", 32'(busy), 0);
    chk(tag, "sp", 32'(sp), 32'(exp_sp));
    chk(tag, "pc", 32'(pc), 32'(exp_pc));
    chk_mem(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) exp_mem[i] = init_byte(i);
    exp_sp = 8'h07;
    exp_pc = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "sp", 32'(sp), 32'h07);
    chk("R1", "pc", 32'(pc), 0);
    chk("R1", "done", 32'(done), 0);
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "ram_en", 32'(ram_en), 0);
    chk("R1", "irq_ret", 32'(irq_ret), 0);

    run_cmd("R2", 3'd0, 8'h30, 16'h0, 2'd2, 1'b0);
    chk("R2", "push addr", 32'(mem[8'h08]), 32'(init_byte(8'h30)));
    run_cmd("R3", 3'd1, 8'h40, 16'h0, 2'd2, 1'b0);
    chk("R3", "pop dest", 32'(mem[8'h40]), 32'(init_byte(8'h30)));
    run_cmd("R5", 3'd3, 8'h00, 16'h07FE, 2'd0, 1'b0);
    chk("R4", "long ret lo", 32'(mem[8'h08]), 32'h07);
    chk("R4", "long ret hi", 32'(mem[8'h09]), 32'h00);
    run_cmd("R6", 3'd2, 8'h00, 16'hF123, 2'd0, 1'b0);
    chk("R6", "page carry pc", 32'(pc), 32'h0923);
    chk("R4", "short ret lo", 32'(mem[8'h0A]), 32'h00);
    chk("R4", "short ret hi", 32'(mem[8'h0B]), 32'h08);
    run_cmd("R7", 3'd4, 8'h00, 16'h0, 2'd0, 1'b0);
    chk("R7", "ret pc", 32'(pc), 32'h0800);
    run_cmd("R8", 3'd5, 8'h00, 16'h0, 2'd0, 1'b0);
    chk("R8", "reti pc", 32'(pc), 32'h0007);
    run_cmd("R11", 3'd0, 8'h55, 16'h0, 2'd1, 1'b1);

    // undefined opcode is ignored (R11)
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd6;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11", "bad op en", 32'(ram_en), 0);
    chk("R11", "bad op busy", 32'(busy), 0);
    @(negedge clk);
    chk("R11", "bad op done", 32'(done), 0);
    chk("R11", "bad op sp", 32'(sp), 32'(exp_sp));
    chk("R11", "bad op pc", 32'(pc), 32'(exp_pc));

    // wrap around zero (R9)
    while (exp_sp != 8'h00) run_cmd("R3", 3'd1, 8'h70, 16'h0, 2'd2, 1'b0);
    run_cmd("R9", 3'd1, 8'h71, 16'h0, 2'd2, 1'b0);
    chk("R9", "sp wrap down", 32'(sp), 32'hFF);
    run_cmd("R9", 3'd0, 8'h90, 16'h0, 2'd2, 1'b0);
    chk("R9", "sp wrap up", 32'(sp), 32'h00);
    chk("R9", "write at 00", 32'(mem[8'h00]), 32'(exp_mem[8'h90]));

    for (int n = 0; n < 300; n++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 5));
      run_cmd((op == 3'd0) ? "R2" : (op == 3'd1) ? "R3" : (op == 3'd2) ? "R6" :
              (op == 3'd3) ? "R5" : (op == 3'd4) ? "R7" : "R8",
              op, 8'($urandom), 16'($urandom), 2'($urandom), 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule